// File: doc/BRIEF.md
# I2C Receive Wait and Interrupt Sequencer

This block is the byte-level controller that sits above the bit engine of an I2C interface. It counts SCL falling edges within each byte and decides when to raise an interrupt, when to hold SCL low and when the acknowledge clock may be generated. When wait interrupts are enabled on a received data byte in acknowledge mode, firmware is interrupted twice per byte. The first interrupt comes after the last data bit, with SCL stretched, so firmware can inspect the byte before choosing ACK or NACK. The second comes after the acknowledge clock.

The bit engine supplies single-cycle strobes for SCL falling edges and for START and STOP detection, plus a transfer-direction level. The register interface supplies single-cycle write strobes for the data shift register and for the clock control register that carries the ACK bit. An internal wait flag records which of the two registers was written last. Software reads it to learn which interrupt point it has reached.

Top module: `i2c_rx_wait_seq`

## Requirements
- R1: After reset `pend_n`=1, `irq`=0, `scl_hold`=0, `wait_flag`=0 and `ack_clk_en`=0. The block then treats the next byte as an address byte.
- R2: The wait stop occurs on the 8th SCL fall of a received data byte (`xmit`=0, not the address byte) when `ack_mode`=1 and `wait_ie`=1. At that fall `irq` pulses, `pend_n` goes to 0, `scl_hold` goes to 1 and `ack_clk_en` stays 0.
- R3: In the wait stop, a `wr_ctrl` strobe releases SCL (`scl_hold`=0) and sets `pend_n`=1. It also asserts `ack_clk_en` until the acknowledge fall.
- R4: The 9th SCL fall of every byte is the acknowledge fall, in any mode. At that fall `irq` pulses, `pend_n`=0 and `scl_hold`=1.
- R5: In the acknowledge stop, only a `wr_data` strobe releases SCL and sets `pend_n`=1. A `wr_ctrl` strobe there leaves SCL held.
- R6: A `wr_data` strobe sets `wait_flag` when the wait stop is armed. Armed means `ack_mode`=1, `wait_ie`=1, `xmit`=0 and the next byte is not an address byte. A `wr_ctrl` strobe clears `wait_flag`.
- R7: During transmission (`xmit`=1) and during the address byte after a START, the 8th fall does not stop the bus and `wait_flag` stays 0.
- R8: With `ack_mode`=0, `wait_ie` has no effect. There is no stop at the 8th fall and a `wr_data` strobe does not set `wait_flag`.
- R9: A `wr_data` strobe during the wait stop is ignored. SCL stays held, `pend_n` stays 0 and the acknowledge phase does not start.
- R10: On `stop_det`, `irq` pulses exactly when `stop_ie`=1. `pend_n` keeps its value.
- R11: `start_det` or `stop_det` clears the bit count, releases SCL and clears `wait_flag`. `start_det` also marks the next byte as an address byte.
- R12: `irq` is a single-cycle pulse per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_fall | input | 1 | Strobe for an SCL falling edge from the bit engine |
| start_det | input | 1 | Strobe for a detected START condition |
| stop_det | input | 1 | Strobe for a detected STOP condition |
| xmit | input | 1 | Transfer direction: 1 = transmitting, 0 = receiving |
| wr_data | input | 1 | Strobe for a write to the data shift register |
| wr_ctrl | input | 1 | Strobe for a write to the clock control register |
| stop_ie | input | 1 | Enables an interrupt on a STOP condition |
| wait_ie | input | 1 | Enables the stop before the acknowledge clock |
| ack_mode | input | 1 | ACK bit value: 1 = acknowledge, 0 = no acknowledge |
| irq | output | 1 | Interrupt request pulse |
| pend_n | output | 1 | Pending flag, 0 = interrupt pending |
| scl_hold | output | 1 | Holds SCL low while 1 |
| ack_clk_en | output | 1 | Permits the acknowledge clock to be generated |
| wait_flag | output | 1 | Internal wait flag, readable by software |

## Verification
A miscounted bit position becomes visible within one byte. The stop then lands on the wrong falling edge, or `ack_clk_en` opens a cycle early or late. The bench checks every edge of a byte, so the first misplaced fall is reported. A wrong hold state is visible on the first register strobe that follows. Either SCL releases when it should stay held, or it stays held after a valid resume. A stale wait flag appears on `wait_flag` one cycle after the strobe that should have changed it.

// File: rtl/i2c_rx_wait_seq.sv
module i2c_rx_wait_seq #(
  parameter int BYTE_BITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_fall,
  input  logic start_det,
  input  logic stop_det,
  input  logic xmit,
  input  logic wr_data,
  input  logic wr_ctrl,
  input  logic stop_ie,
  input  logic wait_ie,
  input  logic ack_mode,
  output logic irq,
  output logic pend_n,
  output logic scl_hold,
  output logic ack_clk_en,
  output logic wait_flag
);
  localparam int CNT_W = $clog2(BYTE_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(BYTE_BITS - 1);
  localparam logic [CNT_W-1:0] ACK_SLOT  = CNT_W'(BYTE_BITS);

  typedef enum logic [1:0] {RUN, HOLD_DATA, HOLD_ACK} phase_t;

  phase_t           phase;
  logic [CNT_W-1:0] cnt;
  logic             addr_byte;
  logic             armed;
  logic             bus_evt;

  assign armed      = ack_mode && wait_ie && !xmit && !addr_byte;
  assign bus_evt    = start_det || stop_det;
  assign scl_hold   = (phase != RUN);
  assign ack_clk_en = (phase == RUN) && (cnt == ACK_SLOT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= RUN;
      cnt       <= '0;
      addr_byte <= 1'b1;
      pend_n    <= 1'b1;
      irq       <= 1'b0;
      wait_flag <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (bus_evt) begin
        phase     <= RUN;
        cnt       <= '0;
        wait_flag <= 1'b0;
        if (start_det) addr_byte <= 1'b1;
        if (stop_det && stop_ie) irq <= 1'b1;
      end else begin
        case (phase)
          RUN: if (scl_fall) begin
            if (cnt == ACK_SLOT) begin
              cnt       <= '0;
              addr_byte <= 1'b0;
              phase     <= HOLD_ACK;
              pend_n    <= 1'b0;
              irq       <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
              if (cnt == LAST_DATA && armed) begin
                phase  <= HOLD_DATA;
                pend_n <= 1'b0;
                irq    <= 1'b1;
              end
            end
          end
          HOLD_DATA: if (wr_ctrl) begin
            phase  <= RUN;
            pend_n <= 1'b1;
          end
          HOLD_ACK: if (wr_data) begin
            phase  <= RUN;
            pend_n <= 1'b1;
          end
          default: phase <= RUN;
        endcase
        if (wr_ctrl) wait_flag <= 1'b0;
        else if (wr_data && phase != HOLD_DATA && armed) wait_flag <= 1'b1;
      end
    end
  end

  AST_HOLD_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_hold) |-> (irq && !pend_n)); // R4
  AST_NO_ACK_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    scl_hold |-> !ack_clk_en); // R2
  AST_WAIT_NEEDS_RX_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wait_flag) |-> ($past(wr_data) && !$past(xmit) && $past(ack_mode))); // R7
  AST_STOP_KEEPS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det && !start_det) |=> (pend_n == $past(pend_n))); // R10
  AST_BUS_EVT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det || stop_det) |=> (!scl_hold && !wait_flag)); // R11
  AST_DATA_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == HOLD_DATA && wr_data && !wr_ctrl && !start_det && !stop_det) |=> scl_hold); // R9
endmodule

// File: tb/tb_i2c_rx_wait_seq.sv
module tb_i2c_rx_wait_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_fall = 0, start_det = 0, stop_det = 0, xmit = 0;
  logic wr_data = 0, wr_ctrl = 0, stop_ie = 0, wait_ie = 0, ack_mode = 0;
  logic irq, pend_n, scl_hold, ack_clk_en, wait_flag;

  always #2 clk = ~clk;

  i2c_rx_wait_seq #(.BYTE_BITS(8)) dut (
    .clk(clk), .rst_n(rst_n), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .xmit(xmit), .wr_data(wr_data), .wr_ctrl(wr_ctrl),
    .stop_ie(stop_ie), .wait_ie(wait_ie), .ack_mode(ack_mode), .irq(irq),
    .pend_n(pend_n), .scl_hold(scl_hold), .ack_clk_en(ack_clk_en),
    .wait_flag(wait_flag));

  typedef struct {
    string    tag;
    logic [4:0] v;
  } exp_t;

  exp_t q[$];
  int vectors = 0;
  int misses = 0;
  bit done = 0;

  // expected vector order: {pend_n, irq, scl_hold, wait_flag, ack_clk_en}
  task automatic step(input string tag, input bit f, input bit s, input bit p,
                      input bit wd, input bit wc, input logic [4:0] e);
    exp_t it;
    @(negedge clk);
    scl_fall = f; start_det = s; stop_det = p; wr_data = wd; wr_ctrl = wc;
    it.tag = tag; it.v = e;
    q.push_back(it);
    @(negedge clk);
    scl_fall = 0; start_det = 0; stop_det = 0; wr_data = 0; wr_ctrl = 0;
  endtask

  task automatic falls(input string tag, input int n, input logic [4:0] e);
    for (int i = 0; i < n; i++) step(tag, 1, 0, 0, 0, 0, e);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t it;
        logic [4:0] act;
        it = q.pop_front();
        act = {pend_n, irq, scl_hold, wait_flag, ack_clk_en};
        vectors++;
        if (act !== it.v) begin
          misses++;
          $display("FAIL %s: got pend/irq/hold/wait/ack=%b expected %b", it.tag, act, it.v);
        end
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      misses++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    wait_ie = 1; ack_mode = 1; xmit = 0; stop_ie = 0;
    step("R1 reset", 0, 0, 0, 0, 0, 5'b10000);
    step("R11 start", 0, 1, 0, 0, 0, 5'b10000);
    falls("R7 address bits", 7, 5'b10000);
    step("R7 address 8th fall no stop", 1, 0, 0, 0, 0, 5'b10001);
    step("R4 address ack fall", 1, 0, 0, 0, 0, 5'b01100);
    step("R12 irq single pulse", 0, 0, 0, 0, 0, 5'b00100);
    step("R5 ctrl write keeps ack hold", 0, 0, 0, 0, 1, 5'b00100);
    step("R6 data write sets wait", 0, 0, 0, 1, 0, 5'b10010);
    falls("R2 data bits", 7, 5'b10010);
    step("R2 wait stop at 8th fall", 1, 0, 0, 0, 0, 5'b01110);
    step("R9 data write in wait stop", 0, 0, 0, 1, 0, 5'b00110);
    step("R3 ctrl write resumes", 0, 0, 0, 0, 1, 5'b10001);
    step("R4 data ack fall", 1, 0, 0, 0, 0, 5'b01100);
    step("R5 data write resumes", 0, 0, 0, 1, 0, 5'b10010);
    ack_mode = 0;
    falls("R8 nack bits", 7, 5'b10010);
    step("R8 nack 8th fall no stop", 1, 0, 0, 0, 0, 5'b10011);
    step("R4 nack ack fall", 1, 0, 0, 0, 0, 5'b01110);
    step("R6 ctrl write clears wait", 0, 0, 0, 0, 1, 5'b00100);
    step("R8 nack data write no wait", 0, 0, 0, 1, 0, 5'b10000);
    ack_mode = 1; xmit = 1;
    falls("R7 tx bits", 7, 5'b10000);
    step("R7 tx 8th fall no stop", 1, 0, 0, 0, 0, 5'b10001);
    step("R4 tx ack fall", 1, 0, 0, 0, 0, 5'b01100);
    step("R7 tx data write no wait", 0, 0, 0, 1, 0, 5'b10000);
    xmit = 0;
    falls("R11 partial byte", 3, 5'b10000);
    step("R6 run data write sets wait", 0, 0, 0, 1, 0, 5'b10010);
    step("R10 stop without enable", 0, 0, 1, 0, 0, 5'b10000);
    falls("R11 count restarted", 7, 5'b10000);
    step("R11 stop at 8th after reset", 1, 0, 0, 0, 0, 5'b01110 & 5'b01100);
    stop_ie = 1;
    step("R10 stop keeps pend", 0, 0, 1, 0, 0, 5'b01000);
    step("R12 stop irq single pulse", 0, 0, 0, 0, 0, 5'b00000);
    step("R11 start keeps pend", 0, 1, 0, 0, 0, 5'b00000);
    falls("R11 partial address", 3, 5'b00000);
    step("R11 restart", 0, 1, 0, 0, 0, 5'b00000);
    falls("R11 address bits", 7, 5'b00000);
    step("R7 address 8th fall", 1, 0, 0, 0, 0, 5'b00001);
    step("R4 address ack fall", 1, 0, 0, 0, 0, 5'b01100);
    step("R6 data write arms wait", 0, 0, 0, 1, 0, 5'b10010);
    step("R10 stop with enable", 0, 0, 1, 0, 0, 5'b11000);
    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule